// File: doc/BRIEF.md
# FIFO Retransmit Setup Controller

This controller sits beside the read port of a single-clock FIFO and runs the setup sequence for retransmit, which rewinds the read pointer to the first memory location so that words already read can be read again. A request is made by holding the active-low retransmit strobe low across a rising clock edge. The controller checks that the request is legal. If it is, it issues a one-cycle rewind command to the read pointer. It then forces the FIFO's empty indication for a fixed number of cycles and holds back reads and writes until setup is over.

The FIFO supplies the number of words written since its last reset and its configured full depth. It combines `empty_force` with its own empty logic: while `empty_force` is high the FIFO must report empty. Once `empty_force` drops, the FIFO reports data present if any words are stored. The block carries no data stream, so every pin is a plain level or pulse with no valid/ready handshake. Reads and writes leave the block as the gated enables `rd_go` and `wr_go`, and these stand in for the raw enables at the FIFO's pointers.

Top module: `fifo_retx_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises with no request, `ptr_rewind`, `empty_force` and `retx_err` are 0 and `write_ok` is 1.
- R2: A legal request raises `ptr_rewind` for exactly the one cycle after the sampling edge. A request is legal when `retx_n` is 0 at a rising edge with no setup in progress, `rd_en_n` and `wr_en_n` are 1 at that edge and at the edge before it, and 1 <= `words_written` <= `depth_full` - 2.
- R3: After a legal request, `empty_force` is 1 for exactly SETUP_CYC (default 3) cycles starting the cycle after the edge, and 0 afterwards.
- R4: `rd_go` is 0 whenever `empty_force` is 1; otherwise it equals the inverse of `rd_en_n`.
- R5: `write_ok` is 0 from the cycle after a legal request until `empty_force` falls or WR_HOLD (default 14) cycles have passed, whichever is first. `wr_go` is the inverse of `wr_en_n` gated by `write_ok`.
- R6: A request that breaks the enable condition of R2 starts no setup: `ptr_rewind` and `empty_force` stay 0, and `retx_err` is 1 for the one cycle after the edge.
- R7: A request with `words_written` = 0 or `words_written` > `depth_full` - 2 starts no setup and raises `retx_err` for one cycle, as in R6.
- R8: A request sampled while `empty_force` is 1 is ignored. It raises no `retx_err`, does not restart the sequence, and leaves the setup length unchanged.
- R9: After setup ends, each read needs `rd_en_n` low in its own cycle: `rd_go` is 1 only in cycles with `rd_en_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| retx_n | input | 1 | Retransmit strobe, active low |
| rd_en_n | input | 1 | Raw read enable, active low |
| wr_en_n | input | 1 | Raw write enable, active low |
| words_written | input | CNT_W | Words written since the last FIFO reset |
| depth_full | input | CNT_W | Configured full depth in words |
| ptr_rewind | output | 1 | One-cycle command to reset the read pointer to location 0 |
| empty_force | output | 1 | Forces the empty flag while setup runs |
| write_ok | output | 1 | Writes permitted |
| rd_go | output | 1 | Gated read enable, active high |
| wr_go | output | 1 | Gated write enable, active high |
| retx_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions assume that `words_written` and `depth_full` are settled at every edge and that `depth_full` stays above 2, so the legal window is never empty. The stimulus holds `depth_full` within that range. Random cycles draw the strobe and both enables with biased probabilities, and the word count is drawn around both ends of the window. Directed cases cover the exact boundaries, an enable that was active on the edge before the request, and a second request made during setup.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  // True when the written count lies in the legal retransmit window [1, depth-2].
  function automatic logic count_in_window(input logic [31:0] cnt, input logic [31:0] depth);
    return (cnt >= 32'd1) && ((cnt + 32'd2) <= depth);
  endfunction
endpackage

// File: rtl/rtx_precheck.sv
module rtx_precheck #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retx_n,
  input  logic             rd_en_n,
  input  logic             wr_en_n,
  input  logic [CNT_W-1:0] words_written,
  input  logic [CNT_W-1:0] depth_full,
  output logic             req,
  output logic             legal
);
  import rtx_pkg::*;

  logic idle_prev;
  logic cnt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_prev <= 1'b1;
    else        idle_prev <= rd_en_n & wr_en_n;
  end

  assign cnt_ok = count_in_window(32'(words_written), 32'(depth_full));
  assign req    = ~retx_n;
  assign legal  = rd_en_n & wr_en_n & idle_prev & cnt_ok;
endmodule

// File: rtl/rtx_sequencer.sv
module rtx_sequencer #(
  parameter int SETUP_CYC = 3,
  parameter int WR_HOLD   = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic reject,
  output logic busy,
  output logic rewind,
  output logic err,
  output logic permit
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int HW = $clog2(WR_HOLD + 1);
  localparam logic [SW-1:0] SLOAD = SW'(SETUP_CYC);
  localparam logic [HW-1:0] HMAX  = HW'(WR_HOLD);

  logic [SW-1:0] left;
  logic [HW-1:0] held;

  assign busy   = (left != '0);
  assign permit = ~busy | (held >= HMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left   <= '0;
      held   <= '0;
      rewind <= 1'b0;
      err    <= 1'b0;
    end else begin
      rewind <= start;
      err    <= reject;
      if (start) begin
        left <= SLOAD;
        held <= '0;
      end else if (busy) begin
        left <= left - 1'b1;
        if (held < HMAX) held <= held + 1'b1;
      end
    end
  end

  // run length monitor for the setup window
  logic [SW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < (SW+1)'(SETUP_CYC)));
  p_rewind_in_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |-> busy);
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rewind && err));
endmodule

// File: rtl/fifo_retx_ctrl.sv
module fifo_retx_ctrl #(
  parameter int CNT_W     = 16,
  parameter int SETUP_CYC = 3,
  parameter int WR_HOLD   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retx_n,
  input  logic             rd_en_n,
  input  logic             wr_en_n,
  input  logic [CNT_W-1:0] words_written,
  input  logic [CNT_W-1:0] depth_full,
  output logic             ptr_rewind,
  output logic             empty_force,
  output logic             write_ok,
  output logic             rd_go,
  output logic             wr_go,
  output logic             retx_err
);
  logic req, legal, busy, start, reject;

  rtx_precheck #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .retx_n(retx_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .words_written(words_written), .depth_full(depth_full),
    .req(req), .legal(legal)
  );

  assign start  = req & ~busy & legal;
  assign reject = req & ~busy & ~legal;

  rtx_sequencer #(.SETUP_CYC(SETUP_CYC), .WR_HOLD(WR_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reject(reject),
    .busy(busy), .rewind(ptr_rewind), .err(retx_err), .permit(write_ok)
  );

  assign empty_force = busy;
  assign rd_go       = ~rd_en_n & ~busy;
  assign wr_go       = ~wr_en_n & write_ok;

  p_no_read_in_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty_force |-> !rd_go);
  p_no_write_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !write_ok |-> !wr_go);
  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_force && !retx_n) |=> !retx_err);
  p_rewind_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptr_rewind) |-> $past(!retx_n && rd_en_n && wr_en_n));
endmodule

// File: tb/fifo_retx_ctrl_test.sv
module fifo_retx_ctrl_test;
  localparam int CNT_W = 16;
  localparam int SETUP = 3;

  logic clk = 0, rst_n = 0;
  logic retx_n = 1, rd_en_n = 1, wr_en_n = 1;
  logic [CNT_W-1:0] words_written = 0, depth_full = 100;
  logic ptr_rewind, empty_force, write_ok, rd_go, wr_go, retx_err;

  int checks = 0, errors = 0;
  int m_left = 0;
  bit m_prev_ok = 1, m_rew = 0, m_err = 0;

  always #2 clk = ~clk;

  fifo_retx_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .retx_n(retx_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .words_written(words_written), .depth_full(depth_full),
    .ptr_rewind(ptr_rewind), .empty_force(empty_force), .write_ok(write_ok),
    .rd_go(rd_go), .wr_go(wr_go), .retx_err(retx_err)
  );

  function automatic bit legal_req(bit rn, bit wn, bit prev, int cnt, int dep);
    return rn && wn && prev && cnt >= 1 && cnt + 2 <= dep;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance one edge with the current inputs, update model, compare
  task automatic step();
    bit busy0 = (m_left != 0);
    bit rq = !retx_n && !busy0;
    bit lg = legal_req(rd_en_n, wr_en_n, m_prev_ok, int'(words_written), int'(depth_full));
    m_rew = rq && lg;
    m_err = rq && !lg;
    if (m_rew) m_left = SETUP; else if (busy0) m_left--;
    m_prev_ok = rd_en_n && wr_en_n;
    @(posedge clk); #1;
    chk("R2 ptr_rewind", ptr_rewind, m_rew);
    chk("R3 empty_force", empty_force, m_left != 0);
    chk("R5 write_ok", write_ok, m_left == 0);
    chk("R4/R9 rd_go", rd_go, !rd_en_n && m_left == 0);
    chk("R5 wr_go", wr_go, !wr_en_n && m_left == 0);
    chk("R6/R7 retx_err", retx_err, m_err);
  endtask

  task automatic drive(bit rt, bit rn, bit wn, int cnt);
    retx_n = rt; rd_en_n = rn; wr_en_n = wn; words_written = CNT_W'(cnt);
  endtask

  initial begin
    void'($urandom(1234));
    #5;
    chk("R1 rewind in reset", ptr_rewind, 1'b0);
    chk("R1 empty_force in reset", empty_force, 1'b0);
    chk("R1 write_ok in reset", write_ok, 1'b1);
    chk("R1 err in reset", retx_err, 1'b0);
    @(negedge clk); rst_n = 1;
    drive(1, 1, 1, 10); step(); step();

    // R2/R3 legal request, then full setup
    drive(0, 1, 1, 10); step();
    drive(1, 1, 1, 10);
    for (int i = 0; i < 5; i++) step();
    // R8 request during setup ignored
    drive(0, 1, 1, 10); step();
    drive(0, 1, 1, 10); step();
    chk("R8 err during busy", retx_err, 1'b0);
    drive(1, 1, 1, 10); for (int i = 0; i < 4; i++) step();
    // R6 read enable active at edge
    drive(0, 0, 1, 10); step(); drive(1, 1, 1, 10); step();
    // R6 write enable active on previous edge
    drive(1, 1, 0, 10); step(); drive(0, 1, 1, 10); step();
    chk("R6 prev-edge enable rejected", retx_err, 1'b1);
    drive(1, 1, 1, 10); step(); step();
    // R7 boundaries: 0, depth-2, depth-1
    drive(0, 1, 1, 0);  step(); drive(1, 1, 1, 0); step();
    drive(0, 1, 1, 98); step();
    chk("R7 depth-2 accepted", ptr_rewind, 1'b1);
    drive(1, 1, 1, 98); for (int i = 0; i < 4; i++) step();
    drive(0, 1, 1, 99); step();
    chk("R7 depth-1 rejected", retx_err, 1'b1);
    drive(1, 1, 1, 99); step();
    // R9 reads after setup need enable each cycle
    drive(1, 0, 1, 5); step(); drive(1, 1, 1, 5); step(); drive(1, 0, 0, 5); step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      int c = (r < 50) ? int'($urandom_range(0, 3)) : int'($urandom_range(95, 100));
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
            $urandom_range(0, 4) != 0, c);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule